// File: doc/BRIEF.md
# Four-Counter Event Monitor

This block counts hardware events for software profiling. It holds four 32-bit counters. Each counter has its own setup register that picks which event it counts and when it must stop. Every cycle the processor pipeline presents a vector of event pulses, indexed by event code, together with a flag that says whether the processor runs in supervisor or user mode. Software programs the block through a simple register port. It can read and write each counter directly, so it can preload a counter such that bit 31 turns on after a chosen number of events.

A counter counts as overflowed whenever its bit 31 is set. When a counter has overflowed, its setup register enables the condition, and the counter is not frozen, the block raises `pm_irq`, provided the shared control register enables interrupts. A shared freeze stops all four counters at once. Six latency events, codes 76 to 81, are wired only to counters 0 and 1.

Top module: `pmu_quad`

Register map on `reg_addr`:
- 0 to 3: counters 0 to 3.
- 4 to 7: setup of counters 0 to 3. Fields: [7:0] event code, [8] freeze, [9] freeze while `priv_sup`=1, [10] freeze while `priv_sup`=0, [11] overflow condition enable. All other bits read as 0.
- 8: shared control. Fields: [0] freeze all, [1] interrupt enable.
- Any other address reads 0.

## Requirements
- R1: After reset, every counter, setup register and the shared control read 0, and `pm_irq` is 0.
- R2: A counter set to an event code of 2 or more adds one at each clock edge where `ev_vec[code]` is 1. Between register writes, a counter moves by at most one per cycle.
- R3: Event code 1 adds one on every clock edge, whatever `ev_vec` holds.
- R4: Event code 0 never counts.
- R5: With setup bit 8 set, the counter holds its value.
- R6: With setup bit 9 set, the counter holds while `priv_sup`=1. With setup bit 10 set, it holds while `priv_sup`=0. In the other mode it counts.
- R7: With shared bit 0 set, all four counters hold.
- R8: Codes 76 to 81 count on counters 0 and 1. On counters 2 and 3 the same codes never count.
- R9: `pm_irq` is 1 exactly when some counter has bit 31 set, setup bit 11 set and setup bit 8 clear, and shared bit 1 is set.
- R10: When shared bit 1 is clear, when setup bit 11 is clear, or when setup bit 8 is set, an overflowed counter does not raise `pm_irq`.
- R11: An overflowed counter keeps counting and wraps from 0xFFFFFFFF to 0. Bit 31, and therefore the interrupt, stays set until the counter is written or wraps.
- R12: A write to a counter in the same cycle as one of its events loads the written value, and that event is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| ev_vec | input | 256 | Per-cycle event pulses, bit n is event code n |
| priv_sup | input | 1 | 1 in supervisor mode, 0 in user mode |
| pm_irq | output | 1 | Performance-monitor interrupt |

## Verification
The hardest case to reach is a counter crossing into bit 31, and later wrapping past 0xFFFFFFFF. From reset this would take billions of events. The bench instead preloads counters a few steps short of 0x80000000 and of 0xFFFFFFFF through the register port. It then delivers single event pulses and checks the counter value and `pm_irq` after each step. A second hard case is a counter write colliding with an event in the same cycle. The bench raises the write strobe and the event bit on the same clock edge.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int NUM_CTR   = 4;
    localparam int CTR_W     = 32;
    localparam int EVT_W     = 8;
    localparam int NUM_EVT   = 1 << EVT_W;
    localparam int ADDR_W    = 4;
    localparam int REG_W     = 32;

    localparam int ADDR_CTR0 = 0;
    localparam int ADDR_LCR0 = NUM_CTR;
    localparam int ADDR_GCR  = 2 * NUM_CTR;

    localparam logic [EVT_W-1:0] EVT_NONE   = 8'd0;
    localparam logic [EVT_W-1:0] EVT_CYCLE  = 8'd1;
    localparam logic [EVT_W-1:0] EVT_LAT_LO = 8'd76;
    localparam logic [EVT_W-1:0] EVT_LAT_HI = 8'd81;
    localparam int               LAT_CTRS   = 2;

    typedef struct packed {
        logic             cond_en;
        logic             frz_usr;
        logic             frz_sup;
        logic             frz;
        logic [EVT_W-1:0] evt;
    } lcr_t;

    typedef struct packed {
        logic irq_en;
        logic frz_all;
    } gcr_t;

    localparam int LCR_BITS = $bits(lcr_t);

    function automatic logic evt_is_latency(input logic [EVT_W-1:0] code);
        return (code >= EVT_LAT_LO) && (code <= EVT_LAT_HI);
    endfunction

    function automatic logic evt_allowed(input int idx, input logic [EVT_W-1:0] code);
        return (idx < LAT_CTRS) || !evt_is_latency(code);
    endfunction

endpackage

// File: rtl/pmu_ctr_slice.sv
module pmu_ctr_slice
    import pmu_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctr_we,
    input  logic               lcr_we,
    input  logic [CTR_W-1:0]   wdata,
    input  logic [NUM_EVT-1:0] ev_vec,
    input  logic               priv_sup,
    input  logic               frz_all,
    output logic [CTR_W-1:0]   ctr_q,
    output lcr_t               lcr_q,
    output logic               irq_req
);

    logic ev_hit;
    logic mode_frozen;
    logic cnt_en;

    always_comb begin
        if (lcr_q.evt == EVT_NONE)
            ev_hit = 1'b0;
        else if (lcr_q.evt == EVT_CYCLE)
            ev_hit = 1'b1;
        else
            ev_hit = ev_vec[lcr_q.evt];
    end

    assign mode_frozen = priv_sup ? lcr_q.frz_sup : lcr_q.frz_usr;
    assign cnt_en      = ev_hit && evt_allowed(IDX, lcr_q.evt)
                         && !lcr_q.frz && !frz_all && !mode_frozen;

    always_ff @(posedge clk) begin
        if (rst)
            ctr_q <= '0;
        else if (ctr_we)
            ctr_q <= wdata;
        else if (cnt_en)
            ctr_q <= ctr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            lcr_q <= '0;
        else if (lcr_we)
            lcr_q <= lcr_t'(wdata[LCR_BITS-1:0]);
    end

    assign irq_req = ctr_q[CTR_W-1] && lcr_q.cond_en && !lcr_q.frz;

endmodule

// File: rtl/pmu_global_ctl.sv
module pmu_global_ctl
    import pmu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  gcr_t wdata,
    output gcr_t gcr_q
);

    always_ff @(posedge clk) begin
        if (rst)
            gcr_q <= '0;
        else if (we)
            gcr_q <= wdata;
    end

endmodule

// File: rtl/pmu_read_mux.sv
module pmu_read_mux
    import pmu_pkg::*;
(
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_CTR-1:0][CTR_W-1:0] ctr,
    input  lcr_t [NUM_CTR-1:0]            lcr,
    input  gcr_t                          gcr,
    output logic [REG_W-1:0]              rdata
);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (int'(addr) == ADDR_CTR0 + i)
                rdata = ctr[i];
            if (int'(addr) == ADDR_LCR0 + i)
                rdata = REG_W'(lcr[i]);
        end
        if (int'(addr) == ADDR_GCR)
            rdata = REG_W'(gcr);
    end

endmodule

// File: rtl/pmu_quad.sv
module pmu_quad
    import pmu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [NUM_EVT-1:0]  ev_vec,
    input  logic                priv_sup,
    output logic                pm_irq
);

    logic [NUM_CTR-1:0][CTR_W-1:0] ctr_q;
    lcr_t [NUM_CTR-1:0]            lcr_q;
    logic [NUM_CTR-1:0]            irq_req;
    logic [NUM_CTR-1:0]            ctr_we;
    logic [NUM_CTR-1:0]            lcr_we;
    gcr_t                          gcr_q;
    logic                          gcr_we;

    genvar g;
    generate
        for (g = 0; g < NUM_CTR; g++) begin : g_slice
            assign ctr_we[g] = reg_we && (int'(reg_addr) == ADDR_CTR0 + g);
            assign lcr_we[g] = reg_we && (int'(reg_addr) == ADDR_LCR0 + g);

            pmu_ctr_slice #(.IDX(g)) u_slice (
                .clk      (clk),
                .rst      (rst),
                .ctr_we   (ctr_we[g]),
                .lcr_we   (lcr_we[g]),
                .wdata    (reg_wdata),
                .ev_vec   (ev_vec),
                .priv_sup (priv_sup),
                .frz_all  (gcr_q.frz_all),
                .ctr_q    (ctr_q[g]),
                .lcr_q    (lcr_q[g]),
                .irq_req  (irq_req[g])
            );
        end
    endgenerate

    assign gcr_we = reg_we && (int'(reg_addr) == ADDR_GCR);

    pmu_global_ctl u_gcr (
        .clk   (clk),
        .rst   (rst),
        .we    (gcr_we),
        .wdata (gcr_t'(reg_wdata[$bits(gcr_t)-1:0])),
        .gcr_q (gcr_q)
    );

    pmu_read_mux u_rd (
        .addr  (reg_addr),
        .ctr   (ctr_q),
        .lcr   (lcr_q),
        .gcr   (gcr_q),
        .rdata (reg_rdata)
    );

    assign pm_irq = gcr_q.irq_en && (|irq_req);

endmodule

// File: rtl/pmu_quad_chk.sv
module pmu_quad_chk
    import pmu_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          reg_we,
    input logic [ADDR_W-1:0]             reg_addr,
    input logic [REG_W-1:0]              reg_wdata,
    input logic [NUM_CTR-1:0][CTR_W-1:0] ctr_q,
    input lcr_t [NUM_CTR-1:0]            lcr_q,
    input gcr_t                          gcr_q,
    input logic                          pm_irq
);

    logic [NUM_CTR-1:0] cw;
    logic [NUM_CTR-1:0] ovf;

    always_comb begin
        for (int i = 0; i < NUM_CTR; i++) begin
            cw[i]  = reg_we && (int'(reg_addr) == ADDR_CTR0 + i);
            ovf[i] = ctr_q[i][CTR_W-1];
        end
    end

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        pm_irq |-> gcr_q.irq_en);                                    // R10

    AST_IRQ_NEEDS_OVF: assert property (@(posedge clk) disable iff (rst)
        (ovf == '0) |-> !pm_irq);                                    // R9

    genvar g;
    generate
        for (g = 0; g < NUM_CTR; g++) begin : g_chk
            AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
                $past(cw[g]) |-> (ctr_q[g] == $past(reg_wdata)));    // R12

            AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
                !$past(cw[g]) |->
                    (ctr_q[g] == $past(ctr_q[g]) ||
                     ctr_q[g] == $past(ctr_q[g]) + 32'd1));           // R2

            AST_FREEZE_ALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
                (!$past(cw[g]) && $past(gcr_q.frz_all)) |->
                    $stable(ctr_q[g]));                               // R7

            AST_LOCAL_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
                (!$past(cw[g]) && $past(lcr_q[g].frz)) |->
                    $stable(ctr_q[g]));                               // R5

            if (g >= LAT_CTRS) begin : g_lat
                AST_LATENCY_BLOCKED: assert property (@(posedge clk) disable iff (rst)
                    (!$past(cw[g]) && $past(evt_is_latency(lcr_q[g].evt))) |->
                        $stable(ctr_q[g]));                           // R8
            end
        end
    endgenerate

endmodule

bind pmu_quad pmu_quad_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ctr_q     (ctr_q),
    .lcr_q     (lcr_q),
    .gcr_q     (gcr_q),
    .pm_irq    (pm_irq)
);

// File: tb/tb_pmu_quad.sv
module tb_pmu_quad;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [255:0] ev_vec = '0;
    logic        priv_sup = 1'b0;
    logic        pm_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    pmu_quad dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_vec(ev_vec),
        .priv_sup(priv_sup), .pm_irq(pm_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input int code, input int n);
        @(negedge clk);
        ev_vec[code] = 1'b1;
        repeat (n) @(negedge clk);
        ev_vec[code] = 1'b0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 4; i++) wr(4'(4 + i), 32'h0);
        wr(4'd8, 32'h0);
        for (int i = 0; i < 4; i++) wr(4'(i), 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 9; i++) begin
            rd(4'(i), v);
            chk("R1 reset value", v, 32'h0);
        end
        chk("R1 reset irq", {31'd0, pm_irq}, 32'h0);
    endtask

    task automatic t_count_event();
        logic [31:0] v;
        clear_all();
        wr(4'd4, 32'h002);
        pulse(2, 5);
        rd(4'd0, v); chk("R2 code 2 counts pulses", v, 32'd5);
        pulse(7, 3);
        rd(4'd0, v); chk("R2 other event ignored", v, 32'd5);
        wr(4'd5, 32'h02A);
        pulse(42, 7);
        rd(4'd1, v); chk("R2 code 42 on ctr1", v, 32'd7);
    endtask

    task automatic t_cycles();
        logic [31:0] v0, v1;
        clear_all();
        wr(4'd6, 32'h001);
        rd(4'd2, v0);
        repeat (10) @(negedge clk);
        rd(4'd2, v1);
        chk("R3 cycle event", v1 - v0, 32'd10);
    endtask

    task automatic t_code0();
        logic [31:0] v;
        clear_all();
        pulse(0, 6);
        rd(4'd0, v); chk("R4 code 0 no count", v, 32'd0);
    endtask

    task automatic t_local_freeze();
        logic [31:0] v;
        clear_all();
        wr(4'd4, 32'h002);
        pulse(2, 2);
        wr(4'd4, 32'h102);
        pulse(2, 4);
        rd(4'd0, v); chk("R5 local freeze holds", v, 32'd2);
        rd(4'd4, v); chk("R5 setup readback", v, 32'h102);
    endtask

    task automatic t_mode_freeze();
        logic [31:0] v;
        clear_all();
        wr(4'd4, 32'h202);
        priv_sup = 1'b1;
        pulse(2, 4);
        rd(4'd0, v); chk("R6 supervisor frozen", v, 32'd0);
        priv_sup = 1'b0;
        pulse(2, 4);
        rd(4'd0, v); chk("R6 user counts", v, 32'd4);
        wr(4'd4, 32'h402);
        pulse(2, 3);
        rd(4'd0, v); chk("R6 user frozen", v, 32'd4);
        priv_sup = 1'b1;
        pulse(2, 3);
        rd(4'd0, v); chk("R6 supervisor counts", v, 32'd7);
        priv_sup = 1'b0;
    endtask

    task automatic t_freeze_all();
        logic [31:0] v;
        clear_all();
        for (int i = 0; i < 4; i++) wr(4'(4 + i), 32'h003);
        wr(4'd8, 32'h1);
        pulse(3, 5);
        for (int i = 0; i < 4; i++) begin
            rd(4'(i), v); chk("R7 freeze all", v, 32'd0);
        end
        wr(4'd8, 32'h0);
        pulse(3, 2);
        rd(4'd3, v); chk("R7 released", v, 32'd2);
    endtask

    task automatic t_restrict();
        logic [31:0] v;
        clear_all();
        wr(4'd4, 32'd76);
        wr(4'd6, 32'd76);
        wr(4'd7, 32'd81);
        wr(4'd5, 32'd81);
        ev_vec[76] = 1'b1; ev_vec[81] = 1'b1;
        repeat (4) @(negedge clk);
        ev_vec[76] = 1'b0; ev_vec[81] = 1'b0;
        rd(4'd0, v); chk("R8 code 76 on ctr0", v, 32'd4);
        rd(4'd1, v); chk("R8 code 81 on ctr1", v, 32'd4);
        rd(4'd2, v); chk("R8 code 76 blocked ctr2", v, 32'd0);
        rd(4'd3, v); chk("R8 code 81 blocked ctr3", v, 32'd0);
        wr(4'd7, 32'd82);
        pulse(82, 3);
        rd(4'd3, v); chk("R8 code 82 on ctr3", v, 32'd3);
    endtask

    task automatic t_overflow_irq();
        logic [31:0] v;
        clear_all();
        wr(4'd5, 32'h802);
        wr(4'd1, 32'h7FFF_FFFD);
        wr(4'd8, 32'h2);
        pulse(2, 2);
        rd(4'd1, v); chk("R9 not yet overflowed", v, 32'h7FFF_FFFF);
        chk("R9 irq low", {31'd0, pm_irq}, 32'd0);
        pulse(2, 1);
        rd(4'd1, v); chk("R9 overflowed", v, 32'h8000_0000);
        chk("R9 irq high", {31'd0, pm_irq}, 32'd1);
        pulse(2, 2);
        rd(4'd1, v); chk("R11 keeps counting", v, 32'h8000_0002);
        chk("R11 irq sticks", {31'd0, pm_irq}, 32'd1);
        wr(4'd8, 32'h0);
        chk("R10 irq enable clear", {31'd0, pm_irq}, 32'd0);
        wr(4'd8, 32'h2);
        chk("R9 irq back", {31'd0, pm_irq}, 32'd1);
        wr(4'd5, 32'h902);
        chk("R10 frozen no irq", {31'd0, pm_irq}, 32'd0);
        wr(4'd5, 32'h002);
        chk("R10 no cond enable", {31'd0, pm_irq}, 32'd0);
        wr(4'd5, 32'h802);
        wr(4'd1, 32'h10);
        chk("R11 write clears irq", {31'd0, pm_irq}, 32'd0);
        wr(4'd1, 32'hFFFF_FFFF);
        chk("R9 irq at max", {31'd0, pm_irq}, 32'd1);
        pulse(2, 1);
        rd(4'd1, v); chk("R11 wraps", v, 32'h0);
        chk("R11 irq after wrap", {31'd0, pm_irq}, 32'd0);
    endtask

    task automatic t_write_priority();
        logic [31:0] v;
        clear_all();
        wr(4'd4, 32'h002);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h100;
        ev_vec[2] = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        ev_vec[2] = 1'b0;
        rd(4'd0, v); chk("R12 write wins", v, 32'h100);
        pulse(2, 1);
        rd(4'd0, v); chk("R12 counts after", v, 32'h101);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_count_event();
        t_cycles();
        t_code0();
        t_local_freeze();
        t_mode_freeze();
        t_freeze_all();
        t_restrict();
        t_overflow_irq();
        t_write_priority();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule